// File: doc/BRIEF.md
# Diagnostic Status Line with Timed Fault Release

This block drives the single active-high fault line that a small serial-controlled driver chip reports to its host. The line combines live conditions (a short on any output stage, overtemperature, standby) with latched flags. The latched flags are an under-count frame error, an over-count frame error, a held overtemperature indication and a power-up indication. Each latched flag is released at its own clock ordinal of a later frame. By watching when the line drops, the host can therefore tell which failure occurred.

The block sits behind a synchronizer and edge decoder. It receives single-cycle pulses for the select falling edge (frame start), the select rising edge (frame end), and the serial-clock rising and falling edges. It keeps its own clock count for each frame. The ordinals start at 1 with the first serial-clock rising edge after a frame opens, and the count restarts at every frame start.

Top module: `stl_status_top`

## Requirements
- R1: While any bit of `short_i` is 1, `status_o` is 1. With no fault, no latched flag and `standby_i` at 0, `status_o` is 0.
- R2: While `standby_i` is 1, `status_o` is 1.
- R3: A frame that ends (`sel_rise_i`) after fewer than 8 serial-clock rising edges latches an under-count flag. `status_o` is 1 from the cycle after that frame end. The line is not raised before the frame end.
- R4: The under-count flag is cleared by the falling edge of clock ordinal 8 of a later frame. The line is still 1 after ordinal 7.
- R5: The rising edge of clock ordinal 9 in a frame latches an over-count flag. The line is 1 after ordinal 9 and is not raised by ordinal 8.
- R6: The over-count flag is cleared by the falling edge of clock ordinal 2 of a later frame. The line is still 1 after ordinal 1.
- R7: Overtemperature is latched. The latch clears on the falling edge of clock ordinal 4 of a frame only if `overtemp_i` is 0 in that cycle. Otherwise it stays set until a later frame's ordinal 4.
- R8: After reset `status_o` is 1. It stays 1 until the end of the first frame that carries exactly 8 clocks.
- R9: Serial-clock edges that arrive while no frame is open change no flag. An under-count flag survives 8 such clock pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| sel_fall_i | input | 1 | One-cycle pulse: select fell, frame opens |
| sel_rise_i | input | 1 | One-cycle pulse: select rose, frame closes |
| sclk_rise_i | input | 1 | One-cycle pulse: serial clock rose |
| sclk_fall_i | input | 1 | One-cycle pulse: serial clock fell |
| short_i | input | NOUT (8) | Live short-circuit flag per output stage |
| overtemp_i | input | 1 | Live overtemperature flag |
| standby_i | input | 1 | All command bits are zero |
| status_o | output | 1 | Active-high diagnostic status line |

## Verification
The assertions check on every cycle that live shorts, standby and any held latch force the line high. They also check that each latched flag sets on its defining frame event. Finally, they check that a flag only ever drops in the cycle after its own release ordinal, with the overtemperature release also requiring the live flag low. Only the bench scenarios can show the time-ordered behaviour across frames. That includes the line staying high through ordinal 7 or 1 and dropping on 8 or 2, the overtemperature latch surviving a frame in which heat persisted, and clocks outside any frame leaving a flag untouched.

// File: rtl/stl_pkg.sv
package stl_pkg;

  // Index of each latched flag inside the flag vector.
  localparam int FLG_UNDER = 0;
  localparam int FLG_OVER  = 1;
  localparam int FLG_HEAT  = 2;
  localparam int FLG_PWR   = 3;
  localparam int NFLAG     = 4;

  // Saturating increment of a frame clock count.
  function automatic int unsigned sat_inc(input int unsigned c, input int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  // True when the count of rising edges seen so far equals a given ordinal.
  function automatic logic at_ordinal(input int unsigned c, input int unsigned ord);
    return c == ord;
  endfunction

  // A frame is short when it closes with fewer clocks than a full word.
  function automatic logic short_frame(input int unsigned c, input int unsigned bits);
    return c < bits;
  endfunction

  // Reset value of each latched flag: only the power-up flag starts set.
  function automatic logic flag_rst_val(input int idx);
    return idx == FLG_PWR;
  endfunction

endpackage

// File: rtl/stl_frame_tracker.sv
module stl_frame_tracker #(
  parameter int FRAME_BITS = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fall_i,
  input  logic             sel_rise_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  output logic             in_frame_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rise_evt_o,
  output logic             fall_evt_o,
  output logic             close_evt_o
);
  import stl_pkg::*;

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q;

  // Serial clock edges only count while a frame is open and no select edge is present.
  assign rise_evt_o  = in_frame_q & sclk_rise_i & ~sel_fall_i & ~sel_rise_i;
  assign fall_evt_o  = in_frame_q & sclk_fall_i & ~sel_fall_i & ~sel_rise_i;
  assign close_evt_o = in_frame_q & sel_rise_i & ~sel_fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (sel_fall_i) begin
      in_frame_q <= 1'b1;
      cnt_q      <= '0;
    end else if (sel_rise_i) begin
      in_frame_q <= 1'b0;
    end else if (rise_evt_o) begin
      cnt_q <= CNT_W'(sat_inc(int'(cnt_q), CNT_MAX));
    end
  end

  assign in_frame_o = in_frame_q;
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/stl_flag.sv
module stl_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // Set has priority over clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/stl_status_top.sv
module stl_status_top #(
  parameter int NOUT          = 8,
  parameter int FRAME_BITS    = 8,
  parameter int UNDER_CLR_ORD = 8,
  parameter int OVER_CLR_ORD  = 2,
  parameter int HEAT_CLR_ORD  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_fall_i,
  input  logic            sel_rise_i,
  input  logic            sclk_rise_i,
  input  logic            sclk_fall_i,
  input  logic [NOUT-1:0] short_i,
  input  logic            overtemp_i,
  input  logic            standby_i,
  output logic            status_o
);
  import stl_pkg::*;

  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic             in_frame;
  logic [CNT_W-1:0] cnt;
  logic             rise_evt;
  logic             fall_evt;
  logic             close_evt;

  // Named event wires, also observed by the checker.
  logic under_set, under_clr;
  logic over_set, over_clr;
  logic heat_set, heat_clr;
  logic pwr_set, pwr_clr;
  logic under_q, over_q, heat_q, pwr_q;
  logic live_fault;

  logic [NFLAG-1:0] set_v, clr_v, q_v;

  stl_frame_tracker #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_fall_i (sel_fall_i),
    .sel_rise_i (sel_rise_i),
    .sclk_rise_i(sclk_rise_i),
    .sclk_fall_i(sclk_fall_i),
    .in_frame_o (in_frame),
    .cnt_o      (cnt),
    .rise_evt_o (rise_evt),
    .fall_evt_o (fall_evt),
    .close_evt_o(close_evt)
  );

  // The count holds the number of rising edges so far, so a falling edge
  // belongs to ordinal cnt and a rising edge starts ordinal cnt+1.
  assign under_set = close_evt & short_frame(int'(cnt), FRAME_BITS);
  assign under_clr = fall_evt & at_ordinal(int'(cnt), UNDER_CLR_ORD);
  assign over_set  = rise_evt & at_ordinal(int'(cnt), FRAME_BITS);
  assign over_clr  = fall_evt & at_ordinal(int'(cnt), OVER_CLR_ORD);
  assign heat_set  = overtemp_i;
  assign heat_clr  = fall_evt & at_ordinal(int'(cnt), HEAT_CLR_ORD) & ~overtemp_i;
  assign pwr_set   = 1'b0;
  assign pwr_clr   = close_evt & at_ordinal(int'(cnt), FRAME_BITS);

  assign set_v[FLG_UNDER] = under_set;
  assign clr_v[FLG_UNDER] = under_clr;
  assign set_v[FLG_OVER]  = over_set;
  assign clr_v[FLG_OVER]  = over_clr;
  assign set_v[FLG_HEAT]  = heat_set;
  assign clr_v[FLG_HEAT]  = heat_clr;
  assign set_v[FLG_PWR]   = pwr_set;
  assign clr_v[FLG_PWR]   = pwr_clr;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    stl_flag #(.RST_VAL(flag_rst_val(i))) u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_v[i]),
      .clr_i(clr_v[i]),
      .q_o  (q_v[i])
    );
  end

  assign under_q = q_v[FLG_UNDER];
  assign over_q  = q_v[FLG_OVER];
  assign heat_q  = q_v[FLG_HEAT];
  assign pwr_q   = q_v[FLG_PWR];

  assign live_fault = (|short_i) | overtemp_i | standby_i;
  assign status_o   = live_fault | (|q_v);

endmodule

// File: rtl/stl_status_chk.sv
module stl_status_chk #(
  parameter int NOUT          = 8,
  parameter int FRAME_BITS    = 8,
  parameter int UNDER_CLR_ORD = 8,
  parameter int OVER_CLR_ORD  = 2,
  parameter int HEAT_CLR_ORD  = 4,
  parameter int CNT_W         = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NOUT-1:0]  short_i,
  input logic             overtemp_i,
  input logic             standby_i,
  input logic             status_o,
  input logic             in_frame,
  input logic [CNT_W-1:0] cnt,
  input logic             fall_evt,
  input logic             close_evt,
  input logic             rise_evt,
  input logic             under_q,
  input logic             over_q,
  input logic             heat_q,
  input logic             pwr_q
);

  assert_short_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|short_i) |-> status_o);

  assert_standby_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |-> status_o);

  assert_under_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && (int'(cnt) < FRAME_BITS)) |=> (under_q && status_o));

  assert_under_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(under_q) |-> $past(fall_evt && (int'(cnt) == UNDER_CLR_ORD)));

  assert_over_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && (int'(cnt) == FRAME_BITS)) |=> (over_q && status_o));

  assert_over_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(over_q) |-> $past(fall_evt && (int'(cnt) == OVER_CLR_ORD)));

  assert_heat_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(heat_q) |-> $past(fall_evt && !overtemp_i && (int'(cnt) == HEAT_CLR_ORD)));

  assert_heat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp_i |=> heat_q);

  assert_power_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q |-> status_o);

  assert_idle_clocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> !fall_evt && !rise_evt);

endmodule

bind stl_status_top stl_status_chk #(
  .NOUT(NOUT), .FRAME_BITS(FRAME_BITS), .UNDER_CLR_ORD(UNDER_CLR_ORD),
  .OVER_CLR_ORD(OVER_CLR_ORD), .HEAT_CLR_ORD(HEAT_CLR_ORD), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .short_i(short_i), .overtemp_i(overtemp_i),
  .standby_i(standby_i), .status_o(status_o), .in_frame(in_frame), .cnt(cnt),
  .fall_evt(fall_evt), .close_evt(close_evt), .rise_evt(rise_evt),
  .under_q(under_q), .over_q(over_q), .heat_q(heat_q), .pwr_q(pwr_q)
);

// File: tb/tb_stl_status_top.sv
module tb_stl_status_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_fall = 1'b0, sel_rise = 1'b0, sclk_rise = 1'b0, sclk_fall = 1'b0;
  logic [NOUT-1:0] shorts = '0;
  logic overtemp = 1'b0, standby = 1'b0;
  logic status;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic st_rise [1:16];
  logic st_fall [1:16];
  logic st_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  stl_status_top #(.NOUT(NOUT)) dut (
    .clk(clk), .rst_n(rst_n), .sel_fall_i(sel_fall), .sel_rise_i(sel_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .short_i(shorts),
    .overtemp_i(overtemp), .standby_i(standby), .status_o(status)
  );

  task automatic check(input logic got, input logic exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: status=%b expected=%b", what, got, exp);
    end
  endtask

  // 0: select fall, 1: select rise, 2: clock rise, 3: clock fall
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: sel_fall = 1'b1;
      1: sel_rise = 1'b1;
      2: sclk_rise = 1'b1;
      default: sclk_fall = 1'b1;
    endcase
    @(negedge clk);
    sel_fall = 1'b0; sel_rise = 1'b0; sclk_rise = 1'b0; sclk_fall = 1'b0;
    #1;
  endtask

  task automatic run_frame(input int n, input int drop_heat_at);
    pulse(0);
    for (int k = 1; k <= n; k++) begin
      pulse(2); st_rise[k] = status;
      pulse(3); st_fall[k] = status;
      if (k == drop_heat_at) overtemp = 1'b0;
    end
    pulse(1); st_end = status;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(status, 1'b1, "R8 status high after reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 check(status, 1'b1, "R8 still high before first frame");
    run_frame(8, 0);
    check(st_fall[8], 1'b1, "R8 high until frame end");
    check(st_end, 1'b0, "R8/R1 low after first full frame");
  endtask

  task automatic t_short;
    @(negedge clk); shorts[3] = 1'b1; #1;
    check(status, 1'b1, "R1 short on stage 3");
    @(negedge clk); shorts = 8'h80; #1;
    check(status, 1'b1, "R1 short on stage 7");
    @(negedge clk); shorts = '0; #1;
    check(status, 1'b0, "R1 low when shorts clear");
  endtask

  task automatic t_standby;
    @(negedge clk); standby = 1'b1; #1;
    check(status, 1'b1, "R2 standby drives high");
    @(negedge clk); standby = 1'b0; #1;
    check(status, 1'b0, "R2 low after standby ends");
  endtask

  task automatic t_under;
    run_frame(5, 0);
    check(st_fall[5], 1'b0, "R3 not raised before frame end");
    check(st_end, 1'b1, "R3 under-count latched at frame end");
    run_frame(8, 0);
    check(st_fall[7], 1'b1, "R4 held after ordinal 7");
    check(st_fall[8], 1'b0, "R4 released at ordinal 8");
  endtask

  task automatic t_idle_clocks;
    run_frame(3, 0);
    check(st_end, 1'b1, "R9 setup under-count");
    for (int k = 0; k < 8; k++) begin
      pulse(2); pulse(3);
    end
    check(status, 1'b1, "R9 clocks outside frame ignored");
    run_frame(8, 0);
    check(st_fall[8], 1'b0, "R9 cleared by a real frame");
  endtask

  task automatic t_over;
    run_frame(9, 0);
    check(st_rise[8], 1'b0, "R5 not raised by ordinal 8");
    check(st_rise[9], 1'b1, "R5 raised on ordinal 9 rise");
    check(st_end, 1'b1, "R5 held at frame end");
    run_frame(8, 0);
    check(st_fall[1], 1'b1, "R6 held after ordinal 1");
    check(st_fall[2], 1'b0, "R6 released at ordinal 2");
  endtask

  task automatic t_heat;
    @(negedge clk); overtemp = 1'b1;
    repeat (3) @(negedge clk);
    overtemp = 1'b0; #1;
    check(status, 1'b1, "R7 overtemperature latched");
    run_frame(8, 0);
    check(st_fall[3], 1'b1, "R7 held after ordinal 3");
    check(st_fall[4], 1'b0, "R7 released at ordinal 4");
    @(negedge clk); overtemp = 1'b1;
    run_frame(8, 5);
    check(st_fall[5], 1'b1, "R7 not released while hot at ordinal 4");
    check(st_end, 1'b1, "R7 still latched at frame end");
    run_frame(8, 0);
    check(st_fall[4], 1'b0, "R7 released in later frame");
  endtask

  initial begin
    t_reset();
    t_short();
    t_standby();
    t_under();
    t_idle_clocks();
    t_over();
    t_heat();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, status=%b expected=done", status);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule